// File: doc/BRIEF.md
# Coherence Memory Controller with Snoop Broadcast

This block is the central controller that keeps one memory line coherent across two to four private caches. A cache posts a request on its own request channel. The controller picks one requester and broadcasts a snoop query to every other cache. It gathers their replies, writes back any modified copy into the backing line, and then answers the requester with the line data and the state the requester may install.

Only one transaction is in progress at a time. A shared busy output tells every cache that the controller is occupied. Requests that are posted while busy stay pending in their channel, and they are served later in round-robin order. A request asks for data, for store permission, or for both. A store permission grant invalidates every other cached copy. It is the only way a cache may reach the Modified state.

Every channel works like a one-entry queue. A valid flag marks the occupied slot. The slot is emptied by a take pulse (requests), by the answering response (snoops), or by the consumer's ready (replies).

Top module: `coh_mem_ctrl`

## Requirements
- R1: After synchronous reset, busy, req_take, snp_valid and rsp_valid are all low. The first request is served with the line value LINE_INIT.
- R2: A request is taken only while busy is low, with req_take one-hot for one cycle. busy is high from the next cycle on. It falls exactly two cycles after the cycle in which the reply is accepted (rsp_valid and rsp_ready both high), so busy stays high for one extra cycle after acceptance.
- R3: When several requests are pending, the cache served is the first one with a pending request after the previously served index, wrapping around. After reset, cache 0 has top priority.
- R4: From the cycle after the take, snp_valid is high for every cache except the requester. Each bit stays high until that cache answers with snr_valid. snp_inv is 1 exactly when bit 1 of the request kind is set.
- R5: The reply is raised only after every queried cache has answered. It goes to the requester alone, and rsp_valid stays high until rsp_ready is seen.
- R6: If a snoop answer reports state Modified (code 3), its data is written into the line, and the reply carries that data.
- R7: If no answer reports Modified, the reply data is the stored line unchanged.
- R8: For a request kind with bit 1 clear (kind 1 asks for data; kind 0 is served the same way), the granted rsp_state is Exclusive (code 2) when every queried cache answered Invalid (code 0). Otherwise it is Shared (code 1).
- R9: For a request kind with bit 1 set (kind 2 asks for store permission, kind 3 asks for data and permission), the granted rsp_state is Modified (code 3).
- R10: While busy is high, no request is taken. Pending requests keep their valid flag and wait.
- R11: A snoop answer from a cache that has no open query, whether sent while idle or sent by the requester itself, is ignored and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Request slot occupied, one bit per cache |
| req_kind | input | N x 2 | Request kind per cache: bit 0 asks for data, bit 1 asks for store permission |
| req_take | output | N | One-cycle pulse that empties the chosen request slot |
| snp_valid | output | N | Snoop query outstanding, one bit per cache |
| snp_inv | output | 1 | Query type: 1 asks caches to invalidate, 0 asks them to downgrade to Shared |
| snr_valid | input | N | Snoop answer present, one bit per cache |
| snr_state | input | N x 2 | State each answering cache held: 0 I, 1 S, 2 E, 3 M |
| snr_data | input | N x DW | Line data from each answering cache |
| rsp_valid | output | N | Reply present, one bit per cache |
| rsp_ready | input | N | Reply accepted, one bit per cache |
| rsp_state | output | 2 | State granted to the requester |
| rsp_data | output | DW | Line data returned to the requester |
| busy | output | 1 | A transaction is in flight |

## Verification
A wrong internal state shows up at the ports within one transaction. A corrupted round-robin pointer makes the wrong req_take bit fire on the very cycle after the previous reply retires. A lost or stuck query bit appears in snp_valid one cycle after the take, or it hangs the reply forever. A missed writeback or a stale holder flag shows up in rsp_data or rsp_state on the first reply cycle. An ignored answer that still reaches the line is caught by the next reply's data.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    // Caches supported: 2 to 4, so a cache index fits in two bits
    localparam int CCM_IDX_W = 2;
    typedef logic [CCM_IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SNOOP = 2'd1,
        PH_REPLY = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;

    typedef struct packed {
        idx_t who;
        logic want_perm;
    } txn_t;

    // State handed to the requester at the end of a transaction
    function automatic logic [1:0] grant_for(input logic want_perm, input logic others_hold);
        if (want_perm)        return ST_M;
        else if (others_hold) return ST_S;
        else                  return ST_E;
    endfunction

endpackage

// File: rtl/ccm_rr_arb.sv
module ccm_rr_arb
    import ccm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] gnt,
    output idx_t         gnt_idx,
    output logic         any
);

    idx_t last_q;

    always_comb begin
        int c;
        logic found;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            c = (int'(last_q) + k) % N;
            if (!found && req[c]) begin
                found   = 1'b1;
                gnt[c]  = 1'b1;
                gnt_idx = idx_t'(c);
            end
        end
    end

    assign any = |req;

    always_ff @(posedge clk) begin
        if (rst)          last_q <= idx_t'(N - 1);
        else if (advance) last_q <= gnt_idx;
    end

    // R3
    arb_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
    // R3
    arb_live_chk: assert property (@(posedge clk) disable iff (rst) (|req) |-> (|(gnt & req)));

endmodule

// File: rtl/ccm_snoop_gather.sv
module ccm_snoop_gather
    import ccm_pkg::*;
#(
    parameter int N  = 4,
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [N-1:0]        query_mask,
    input  logic [N-1:0]        snr_valid,
    input  logic [N-1:0][1:0]   snr_state,
    input  logic [N-1:0][DW-1:0] snr_data,
    output logic [N-1:0]        pending,
    output logic                all_in,
    output logic                holder,
    output logic                wb_en,
    output logic [DW-1:0]       wb_data
);

    logic [N-1:0] accepted;
    logic [N-1:0] has_copy;
    logic [N-1:0] is_dirty;

    for (genvar j = 0; j < N; j++) begin : g_ans
        assign accepted[j] = pending[j] & snr_valid[j];
        assign has_copy[j] = accepted[j] & (snr_state[j] != ST_I);
        assign is_dirty[j] = accepted[j] & (snr_state[j] == ST_M);
    end

    always_comb begin
        wb_en   = 1'b0;
        wb_data = '0;
        for (int j = 0; j < N; j++) begin
            if (is_dirty[j] && !wb_en) begin
                wb_en   = 1'b1;
                wb_data = snr_data[j];
            end
        end
    end

    assign all_in = ((pending & ~snr_valid) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            holder  <= 1'b0;
        end else if (start) begin
            pending <= query_mask;
            holder  <= 1'b0;
        end else begin
            pending <= pending & ~snr_valid;
            if (|has_copy) holder <= 1'b1;
        end
    end

    // R4
    pending_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ((pending & ~$past(pending)) == '0));

endmodule

// File: rtl/ccm_line.sv
module ccm_line #(
    parameter int          DW   = 32,
    parameter logic [DW-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wb_en,
    input  logic [DW-1:0] wb_data,
    output logic [DW-1:0] line
);

    always_ff @(posedge clk) begin
        if (rst)        line <= INIT;
        else if (wb_en) line <= wb_data;
    end

endmodule

// File: rtl/coh_mem_ctrl.sv
module coh_mem_ctrl
    import ccm_pkg::*;
#(
    parameter int            N         = 4,
    parameter int            DW        = 32,
    parameter logic [DW-1:0] LINE_INIT = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req_valid,
    input  logic [N-1:0][1:0]    req_kind,
    output logic [N-1:0]         req_take,
    output logic [N-1:0]         snp_valid,
    output logic                 snp_inv,
    input  logic [N-1:0]         snr_valid,
    input  logic [N-1:0][1:0]    snr_state,
    input  logic [N-1:0][DW-1:0] snr_data,
    output logic [N-1:0]         rsp_valid,
    input  logic [N-1:0]         rsp_ready,
    output logic [1:0]           rsp_state,
    output logic [DW-1:0]        rsp_data,
    output logic                 busy
);

    phase_t        phase_q;
    txn_t          txn_q;
    logic [N-1:0]  arb_gnt;
    idx_t          arb_idx;
    logic          arb_any;
    logic          take_fire;
    logic [N-1:0]  who_oh;
    logic [N-1:0]  pending;
    logic          all_in;
    logic          holder;
    logic          wb_en;
    logic [DW-1:0] wb_data;
    logic [DW-1:0] line;
    logic          rsp_done;

    ccm_rr_arb #(.N(N)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req_valid),
        .advance (take_fire),
        .gnt     (arb_gnt),
        .gnt_idx (arb_idx),
        .any     (arb_any)
    );

    ccm_snoop_gather #(.N(N), .DW(DW)) u_gather (
        .clk        (clk),
        .rst        (rst),
        .start      (take_fire),
        .query_mask (~arb_gnt),
        .snr_valid  (snr_valid),
        .snr_state  (snr_state),
        .snr_data   (snr_data),
        .pending    (pending),
        .all_in     (all_in),
        .holder     (holder),
        .wb_en      (wb_en),
        .wb_data    (wb_data)
    );

    ccm_line #(.DW(DW), .INIT(LINE_INIT)) u_line (
        .clk     (clk),
        .rst     (rst),
        .wb_en   (wb_en),
        .wb_data (wb_data),
        .line    (line)
    );

    assign take_fire = (phase_q == PH_IDLE) && arb_any;
    assign req_take  = take_fire ? arb_gnt : '0;
    assign who_oh    = N'(1) << txn_q.who;
    assign rsp_valid = (phase_q == PH_REPLY) ? who_oh : '0;
    assign rsp_done  = |(rsp_valid & rsp_ready);
    assign rsp_state = grant_for(txn_q.want_perm, holder);
    assign rsp_data  = line;
    assign snp_valid = pending;
    assign snp_inv   = txn_q.want_perm;
    assign busy      = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            txn_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (take_fire) begin
                    phase_q         <= PH_SNOOP;
                    txn_q.who       <= arb_idx;
                    txn_q.want_perm <= req_kind[arb_idx][1];
                end
                PH_SNOOP: if (all_in) phase_q <= PH_REPLY;
                PH_REPLY: if (rsp_done) phase_q <= PH_DONE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    // R2
    take_idle_chk: assert property (@(posedge clk) disable iff (rst) (|req_take) |-> !busy);
    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst) (|req_take) |=> busy);
    // R2
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst) rsp_done |=> busy ##1 !busy);
    // R5
    reply_after_snoop_chk: assert property (@(posedge clk) disable iff (rst) (|rsp_valid) |-> (snp_valid == '0));
    // R5
    single_rsp_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(rsp_valid));
    // R4
    no_self_snoop_chk: assert property (@(posedge clk) disable iff (rst) (|snp_valid) |-> ((snp_valid & who_oh) == '0));
    // R11
    idle_line_stable_chk: assert property (@(posedge clk) disable iff (rst) (phase_q == PH_IDLE) |=> $stable(line));

endmodule

// File: tb/sim_coh_mem_ctrl.sv
`timescale 1ns/1ps
module sim_coh_mem_ctrl;

    localparam int            N    = 4;
    localparam int            DW   = 32;
    localparam logic [DW-1:0] INIT = 32'hA5A5_0001;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [N-1:0]         req_valid;
    logic [N-1:0][1:0]    req_kind;
    logic [N-1:0]         req_take;
    logic [N-1:0]         snp_valid;
    logic                 snp_inv;
    logic [N-1:0]         snr_valid;
    logic [N-1:0][1:0]    snr_state;
    logic [N-1:0][DW-1:0] snr_data;
    logic [N-1:0]         rsp_valid;
    logic [N-1:0]         rsp_ready;
    logic [1:0]           rsp_state;
    logic [DW-1:0]        rsp_data;
    logic                 busy;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] mem_m;
    int last_m;
    int force_mode;

    always #2.5 clk = ~clk;

    coh_mem_ctrl #(.N(N), .DW(DW), .LINE_INIT(INIT)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_take(req_take), .snp_valid(snp_valid), .snp_inv(snp_inv),
        .snr_valid(snr_valid), .snr_state(snr_state), .snr_data(snr_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_state(rsp_state),
        .rsp_data(rsp_data), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rr_next(input logic [N-1:0] mask);
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (last_m + k) % N;
            if (mask[c]) return c;
        end
        return -1;
    endfunction

    // Starts and ends at 1 ns after a falling edge
    task automatic serve_one();
        int w, guard, mi, cnt;
        logic [N-1:0] others, exp_oh;
        logic [1:0] st [N];
        logic [DW-1:0] dat [N];
        logic [1:0] kind, exp_st;
        bit hold, spur;
        w = rr_next(req_valid);
        guard = 0;
        while (req_take == '0 && guard < 50) begin
            @(negedge clk); #1; guard++;
        end
        exp_oh = N'(1) << w;
        chk(req_take == exp_oh, "R3 round-robin winner", req_take, exp_oh);
        chk(!busy, "R2 busy low at take", busy, 0);
        last_m = w;
        kind = req_kind[w];
        @(negedge clk);
        req_valid[w] = 1'b0;
        #1;
        others = '1; others[w] = 1'b0;
        chk(busy, "R2 busy high after take", busy, 1);
        chk(snp_valid == others, "R4 queries to all but requester", snp_valid, others);
        chk(snp_inv == kind[1], "R4 query type", snp_inv, kind[1]);
        chk(req_take == '0, "R10 no take while busy", req_take, 0);
        mi = -1;
        if (force_mode == 2 || (force_mode == 3 && $urandom % 3 == 0)) begin
            mi = (w + 1 + int'($urandom % (N - 1))) % N;
        end
        hold = 0;
        for (int j = 0; j < N; j++) begin
            if (j == mi) st[j] = 2'd3;
            else if (mi >= 0 || force_mode == 0) st[j] = 2'd0;
            else if (force_mode == 1) st[j] = 2'd1;
            else st[j] = 2'($urandom % 3);
            dat[j] = $urandom;
            if (j != w && st[j] != 2'd0) hold = 1;
            if (j != w && st[j] == 2'd3) mem_m = dat[j];
        end
        spur = ($urandom % 4 == 0);
        cnt = 0;
        for (int j = 0; j < N; j++) begin
            if (j == w) continue;
            if ($urandom % 2 == 1) begin
                @(negedge clk); #1;
                chk(rsp_valid == '0, "R5 no reply while queries open", rsp_valid, 0);
            end
            snr_valid[j] = 1'b1; snr_state[j] = st[j]; snr_data[j] = dat[j];
            if (spur && cnt == 0) begin
                // R11: answer from the requester itself must be ignored
                snr_valid[w] = 1'b1; snr_state[w] = 2'd3; snr_data[w] = ~mem_m;
            end
            @(negedge clk);
            snr_valid = '0;
            #1;
            cnt++;
            if (cnt < N - 1) begin
                chk(rsp_valid == '0, "R5 no reply before all answers", rsp_valid, 0);
                chk(snp_valid[j] == 1'b0, "R4 query cleared by answer", snp_valid, 0);
            end
        end
        exp_st = kind[1] ? 2'd3 : (hold ? 2'd1 : 2'd2);
        chk(rsp_valid == exp_oh, "R5 reply to requester", rsp_valid, exp_oh);
        chk(snp_valid == '0, "R5 queries closed at reply", snp_valid, 0);
        chk(rsp_state == exp_st, kind[1] ? "R9 permission grant" : "R8 data grant", rsp_state, exp_st);
        chk(rsp_data == mem_m, (mi >= 0) ? "R6 writeback data" : "R7 line data", rsp_data, mem_m);
        repeat ($urandom % 3) begin
            @(negedge clk); #1;
            chk(rsp_valid == exp_oh, "R5 reply held until ready", rsp_valid, exp_oh);
        end
        rsp_ready[w] = 1'b1;
        @(negedge clk);
        rsp_ready[w] = 1'b0;
        #1;
        chk(busy && rsp_valid == '0, "R2 busy kept one cycle after accept", {busy, rsp_valid}, 1 << N);
        chk(req_take == '0, "R10 no take in release cycle", req_take, 0);
        @(negedge clk); #1;
        chk(!busy, "R2 busy released", busy, 0);
    endtask

    task automatic serve_round(input logic [N-1:0] mask, input logic [N-1:0][1:0] kinds);
        @(negedge clk);
        req_valid = mask;
        req_kind  = kinds;
        #1;
        while (req_valid != '0) serve_one();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        rst = 1'b1;
        req_valid = '0; req_kind = '0; snr_valid = '0; snr_state = '0;
        snr_data = '0; rsp_ready = '0;
        mem_m = INIT; last_m = N - 1; force_mode = 3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!busy && req_take == '0 && snp_valid == '0 && rsp_valid == '0,
            "R1 reset state", {busy, req_take, snp_valid, rsp_valid}, 0);

        // R11: stray answer while idle
        @(negedge clk);
        snr_valid[1] = 1'b1; snr_state[1] = 2'd3; snr_data[1] = 32'hDEAD_BEEF;
        @(negedge clk);
        snr_valid = '0;
        #1;
        chk(!busy && rsp_valid == '0, "R11 idle answer ignored", {busy, rsp_valid}, 0);

        // R1 R7 R8: first data request, nobody holds the line -> E with INIT
        force_mode = 0; serve_round(4'b0001, {2'd0, 2'd0, 2'd0, 2'd1});
        // R8: others shared -> S
        force_mode = 1; serve_round(4'b0010, {2'd0, 2'd0, 2'd0, 2'd1});
        // R8: kind 0 served as data
        force_mode = 0; serve_round(4'b0100, {2'd0, 2'd0, 2'd0, 2'd0});
        // R9: permission only
        force_mode = 1; serve_round(4'b1000, {2'd2, 2'd0, 2'd0, 2'd0});
        // R6 R9: data plus permission with a dirty copy elsewhere
        force_mode = 2; serve_round(4'b0001, {2'd0, 2'd0, 2'd0, 2'd3});
        // R6 R8: data request with dirty copy
        force_mode = 2; serve_round(4'b0100, {2'd0, 2'd1, 2'd0, 2'd0});
        // R3 R10: all caches at once
        force_mode = 3; serve_round(4'b1111, {2'd1, 2'd2, 2'd3, 2'd1});

        // Random mix
        for (int r = 0; r < 80; r++) begin
            logic [N-1:0] m;
            logic [N-1:0][1:0] k;
            m = N'($urandom);
            if (m == '0) m = N'(1) << ($urandom % N);
            k = (2 * N)'($urandom);
            serve_round(m, k);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule